// File: doc/BRIEF.md
# Platform-Level Interrupt Controller Core

This block gathers a configurable set of external interrupt inputs and steers them to a configurable set of hart contexts. Each context has one request line. Every source passes through its own gateway, which turns its raw input into a pending flag. A source is configured as level-style or edge-style. In edge style, the gateway either queues edges that arrive while the source is busy, or discards them.

Software configures the block through a single-cycle register port. It sets a priority for each source. For each context it sets a mask of enabled sources and a priority threshold. A context takes an interrupt by reading its claim register. The read returns the identifier of the best eligible source and marks that source as in service. When the handler has finished, the context writes the same identifier back as a completion, which releases the source.

Supervisor-level register accesses pass only when a delegation bit is set. Only machine-level accesses can change that bit.

The register address is {group[11:8], index[7:0]}. The groups are:

| Group | Name | Index | Contents |
|---|---|---|---|
| 0 | priority | source ID | priority of that source |
| 1 | mode | source ID | bit0: 1 = level, 0 = edge; bit1: 1 = queue edges, 0 = drop edges |
| 2 | pending | none | read-only; bit s holds source s |
| 3 | enable | context | bit s enables source s |
| 4 | threshold | context | priority threshold |
| 5 | claim | context | read to claim; write an ID to complete |
| 7 | delegation | 0 | bit0 is the delegation bit |

Top module: `plic_core`

## Requirements
- R1: After reset, every irq_out bit is 0, rd_valid is 0, and every register reads 0, including a claim read.
- R2: A claim read returns the ID of the eligible source with the largest priority value. Priority ties go to the lowest source ID.
- R3: A source reaches a context only when bit s of that context's enable register (group 3) is 1. A disabled source neither raises that context's line nor is returned by its claim.
- R4: A source is eligible for a context only if its priority is nonzero and not below the context's threshold (group 4). irq_out[c] is 1 exactly when context c has an eligible source. Equal priority and threshold counts as eligible.
- R5: A claim read clears the returned source's pending bit and puts the source in service. A claim read that finds no eligible source returns 0.
- R6: Level mode (mode bit0 = 1): while a source is in service its pending bit stays 0, even with the input held high. After completion the pending bit rises again if the input is still high.
- R7: Edge drop mode (mode = 0): rising edges seen while the source is pending or in service are discarded.
- R8: Edge queue mode (mode = 2): rising edges seen while the source is pending or in service are counted, up to QDEPTH. Each completion delivers one counted edge as a new pending request.
- R9: A completion write (group 5) whose data is not the ID of a source in service is ignored.
- R10: While the delegation bit (group 7, bit0) is 0, supervisor accesses (req_sup = 1) are ignored and read 0. Supervisor accesses never change the delegation bit and always read it as 0.
- R11: Read data appears on rd_data with rd_valid = 1 exactly one cycle after the read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_src | input | N_SRC | Raw inputs; bit i is source ID i+1 |
| req_valid | input | 1 | Register access this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sup | input | 1 | 1 = supervisor-level access |
| req_addr | input | 12 | {group, index} |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| irq_out | output | N_CTX | Request line for each context |

## Verification
The bench builds the block with 6 sources, 2 contexts, 3-bit priorities and an edge queue depth of 2. The shallow queue lets four edges overrun the counter within a few cycles. Two contexts are enough to show one source enabled for one context and masked from the other. Priority ties, a priority equal to the threshold, stray completions and supervisor accesses with and without delegation are each driven in their own scenario.

// File: rtl/plic_pkg.sv
package plic_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;

  typedef enum logic [3:0] {
    GRP_PRIO  = 4'h0,
    GRP_MODE  = 4'h1,
    GRP_PEND  = 4'h2,
    GRP_EN    = 4'h3,
    GRP_THR   = 4'h4,
    GRP_CLAIM = 4'h5,
    GRP_CTRL  = 4'h7
  } reg_grp_e;
endpackage

// File: rtl/plic_gateway.sv
module plic_gateway #(
  parameter int QDEPTH = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic irq_in,
  input  logic level_mode,
  input  logic queue_mode,
  input  logic claim,
  input  logic complete,
  output logic pending,
  output logic in_service
);
  localparam int CNT_W = $clog2(QDEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(QDEPTH);

  logic             irq_d;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             pend_n, svc_n;
  logic             rise;

  assign rise = irq_in & ~irq_d;

  always_comb begin
    pend_n = pending;
    svc_n  = in_service;
    cnt_n  = cnt_q;
    if (claim && pending) begin
      pend_n = 1'b0;
      svc_n  = 1'b1;
    end
    if (complete && in_service) svc_n = 1'b0;
    if (level_mode) begin
      cnt_n = '0;
      if (!pend_n && !svc_n && irq_in) pend_n = 1'b1;
    end else begin
      if (rise) begin
        if (!pend_n && !svc_n && cnt_n == '0) pend_n = 1'b1;
        else if (queue_mode && cnt_n != CNT_MAX) cnt_n = cnt_n + 1'b1;
      end
      if (!pend_n && !svc_n && cnt_n != '0) begin
        pend_n = 1'b1;
        cnt_n  = cnt_n - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_d      <= 1'b0;
      pending    <= 1'b0;
      in_service <= 1'b0;
      cnt_q      <= '0;
    end else begin
      irq_d      <= irq_in;
      pending    <= pend_n;
      in_service <= svc_n;
      cnt_q      <= cnt_n;
    end
  end
endmodule

// File: rtl/plic_target.sv
module plic_target #(
  parameter int N_SRC  = 10,
  parameter int PRIO_W = 3,
  parameter int ID_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  cand,
  input  logic [PRIO_W-1:0] prio [N_SRC],
  input  logic [PRIO_W-1:0] thr,
  output logic [ID_W-1:0]   best_id,
  output logic              irq_out
);
  logic [PRIO_W-1:0] best_p;

  always_comb begin
    best_id = '0;
    best_p  = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (cand[i] && prio[i] != '0 && prio[i] >= thr && prio[i] > best_p) begin
        best_p  = prio[i];
        best_id = ID_W'(i + 1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_out <= 1'b0;
    else     irq_out <= (best_id != '0);
  end
endmodule

// File: rtl/plic_core.sv
module plic_core
  import plic_pkg::*;
#(
  parameter int N_SRC  = 10,
  parameter int N_CTX  = 9,
  parameter int PRIO_W = 3,
  parameter int QDEPTH = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  irq_src,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_sup,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [N_CTX-1:0]  irq_out
);
  localparam int ID_W   = $clog2(N_SRC + 1);
  localparam int SRC_IW = (N_SRC > 1) ? $clog2(N_SRC) : 1;
  localparam int CTX_IW = (N_CTX > 1) ? $clog2(N_CTX) : 1;
  localparam logic [7:0] SRC_MAX = 8'(N_SRC);
  localparam logic [7:0] CTX_LIM = 8'(N_CTX);

  logic [PRIO_W-1:0] prio_q [N_SRC];
  logic [N_SRC-1:0]  mode_level, mode_queue;
  logic [N_SRC-1:0]  en_q   [N_CTX];
  logic [PRIO_W-1:0] thr_q  [N_CTX];
  logic              deleg_q;

  logic [N_SRC-1:0]  pend_vec, svc_vec, claim_vec, cmpl_vec;
  logic [ID_W-1:0]   best_id [N_CTX];

  reg_grp_e          grp;
  logic [7:0]        idx;
  logic [SRC_IW-1:0] sidx;
  logic [CTX_IW-1:0] cidx;
  logic              src_hit, ctx_hit, acc, wr, rd, rd_claim, wr_claim;
  logic [DATA_W-1:0] rdata_n;

  assign grp     = reg_grp_e'(req_addr[11:8]);
  assign idx     = req_addr[7:0];
  assign sidx    = SRC_IW'(idx - 8'd1);
  assign cidx    = CTX_IW'(idx);
  assign src_hit = (idx != 8'd0) && (idx <= SRC_MAX);
  assign ctx_hit = idx < CTX_LIM;
  assign acc     = req_valid && (req_sup ? (deleg_q && grp != GRP_CTRL) : 1'b1);
  assign wr      = acc && req_write;
  assign rd      = acc && !req_write;
  assign rd_claim = rd && grp == GRP_CLAIM && ctx_hit;
  assign wr_claim = wr && grp == GRP_CLAIM && ctx_hit;

  // Gateways, one per source
  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    assign claim_vec[s] = rd_claim && (best_id[cidx] == ID_W'(s + 1));
    assign cmpl_vec[s]  = wr_claim && (req_wdata == DATA_W'(s + 1));
    plic_gateway #(.QDEPTH(QDEPTH)) u_gw (
      .clk        (clk),
      .rst        (rst),
      .irq_in     (irq_src[s]),
      .level_mode (mode_level[s]),
      .queue_mode (mode_queue[s]),
      .claim      (claim_vec[s]),
      .complete   (cmpl_vec[s]),
      .pending    (pend_vec[s]),
      .in_service (svc_vec[s])
    );
  end

  // Selection, one per context
  for (genvar c = 0; c < N_CTX; c++) begin : g_ctx
    plic_target #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_tgt (
      .clk     (clk),
      .rst     (rst),
      .cand    (pend_vec & en_q[c]),
      .prio    (prio_q),
      .thr     (thr_q[c]),
      .best_id (best_id[c]),
      .irq_out (irq_out[c])
    );
  end

  // Configuration writes
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < N_SRC; s++) prio_q[s] <= '0;
      for (int c = 0; c < N_CTX; c++) begin
        en_q[c]  <= '0;
        thr_q[c] <= '0;
      end
      mode_level <= '0;
      mode_queue <= '0;
      deleg_q    <= 1'b0;
    end else if (wr) begin
      case (grp)
        GRP_PRIO: if (src_hit) prio_q[sidx] <= req_wdata[PRIO_W-1:0];
        GRP_MODE: if (src_hit) begin
          mode_level[sidx] <= req_wdata[0];
          mode_queue[sidx] <= req_wdata[1];
        end
        GRP_EN:   if (ctx_hit) en_q[cidx]  <= req_wdata[N_SRC:1];
        GRP_THR:  if (ctx_hit) thr_q[cidx] <= req_wdata[PRIO_W-1:0];
        GRP_CTRL: if (idx == 8'd0) deleg_q <= req_wdata[0];
        default: ;
      endcase
    end
  end

  // Read mux
  always_comb begin
    rdata_n = '0;
    if (rd) begin
      case (grp)
        GRP_PRIO:  if (src_hit) rdata_n = DATA_W'(prio_q[sidx]);
        GRP_MODE:  if (src_hit) rdata_n = DATA_W'({mode_queue[sidx], mode_level[sidx]});
        GRP_PEND:  rdata_n = DATA_W'({pend_vec, 1'b0});
        GRP_EN:    if (ctx_hit) rdata_n = DATA_W'({en_q[cidx], 1'b0});
        GRP_THR:   if (ctx_hit) rdata_n = DATA_W'(thr_q[cidx]);
        GRP_CLAIM: if (ctx_hit) rdata_n = DATA_W'(best_id[cidx]);
        GRP_CTRL:  if (idx == 8'd0) rdata_n = DATA_W'(deleg_q);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= req_valid && !req_write;
      rd_data  <= rdata_n;
    end
  end
endmodule

// File: rtl/plic_core_chk.sv
module plic_core_chk #(
  parameter int N_SRC  = 10,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_write,
  input logic              req_sup,
  input logic              deleg,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic [N_SRC-1:0]  pend,
  input logic [N_SRC-1:0]  insvc,
  input logic [N_SRC-1:0]  claim_vec,
  input logic [N_SRC-1:0]  cmpl_vec
);
  // R5: a claim goes to at most one source
  a_r5_single_claim: assert property (@(posedge clk) disable iff (rst)
    $onehot0(claim_vec));

  // R5: the claimed source is in service and no longer pending
  a_r5_claim_takes: assert property (@(posedge clk) disable iff (rst)
    (claim_vec != '0) |=> ((($past(claim_vec) & pend) == '0) &&
                           (($past(claim_vec) & ~insvc) == '0)));

  // R6: no new request is forwarded while a source is in service
  a_r6_no_forward: assert property (@(posedge clk) disable iff (rst)
    (pend & insvc) == '0);

  // R9: a completion for a source not in service leaves it idle
  a_r9_stray_complete: assert property (@(posedge clk) disable iff (rst)
    ((cmpl_vec & ~insvc) != '0) |=> (($past(cmpl_vec & ~insvc) & insvc) == '0));

  // R10: a blocked supervisor read returns zero
  a_r10_sup_blocked: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && req_sup && !deleg) |=> (rd_data == '0));

  // R11: read data is valid one cycle after the request
  a_r11_read_latency: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write) |=> rd_valid);
endmodule

bind plic_core plic_core_chk #(.N_SRC(N_SRC), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_sup   (req_sup),
  .deleg     (deleg_q),
  .rd_valid  (rd_valid),
  .rd_data   (rd_data),
  .pend      (pend_vec),
  .insvc     (svc_vec),
  .claim_vec (claim_vec),
  .cmpl_vec  (cmpl_vec)
);

// File: tb/plic_core_bench.sv
module plic_core_bench;
  localparam int NS = 6;
  localparam int NC = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [NS-1:0] irq_src = '0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_sup = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic [NC-1:0] irq_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic last_valid;

  always #5 clk = ~clk;

  plic_core #(.N_SRC(NS), .N_CTX(NC), .PRIO_W(3), .QDEPTH(2)) u_plic_core (
    .clk(clk), .rst(rst), .irq_src(irq_src),
    .req_valid(req_valid), .req_write(req_write), .req_sup(req_sup),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .irq_out(irq_out)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [3:0] g, logic [7:0] i, logic [31:0] d, logic sup = 1'b0);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_sup = sup;
    req_addr = {g, i}; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_sup = 1'b0;
  endtask

  task automatic rd(logic [3:0] g, logic [7:0] i, output logic [31:0] d, input logic sup = 1'b0);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_sup = sup; req_addr = {g, i};
    @(negedge clk);
    req_valid = 1'b0; req_sup = 1'b0;
    d = rd_data;
    last_valid = rd_valid;
  endtask

  task automatic pulse(int b);
    @(negedge clk); irq_src[b] = 1'b1;
    @(negedge clk); irq_src[b] = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 irq_out", 32'(irq_out), 0);
    check("R1 rd_valid idle", 32'(rd_valid), 0);
    rd(4'h5, 8'd0, d);
    check("R1 claim empty", d, 0);
    check("R11 rd_valid after read", 32'(last_valid), 1);
    rd(4'h0, 8'd1, d);
    check("R1 priority reset", d, 0);
  endtask

  task automatic t_priority;
    logic [31:0] d;
    for (int s = 1; s <= 3; s++) wr(4'h1, 8'(s), 32'd1);
    wr(4'h0, 8'd1, 32'd2);
    wr(4'h0, 8'd2, 32'd5);
    wr(4'h0, 8'd3, 32'd5);
    wr(4'h3, 8'd0, 32'h7E);
    irq_src[2:0] = 3'b111;
    idle(3);
    check("R4 line raised", 32'(irq_out[0]), 1);
    rd(4'h5, 8'd0, d);
    check("R2 tie lowest id", d, 2);
    rd(4'h2, 8'd0, d);
    check("R6 pending held while in service", d, 32'h0A);
    rd(4'h5, 8'd0, d);
    check("R2 second claim", d, 3);
    rd(4'h5, 8'd0, d);
    check("R2 lowest priority last", d, 1);
    rd(4'h5, 8'd0, d);
    check("R5 claim none", d, 0);
    irq_src[2:0] = 3'b000;
    for (int s = 1; s <= 3; s++) wr(4'h5, 8'd0, 32'(s));
    idle(2);
    rd(4'h2, 8'd0, d);
    check("R6 no re-raise when low", d, 0);
  endtask

  task automatic t_level;
    logic [31:0] d;
    irq_src[0] = 1'b1;
    idle(2);
    rd(4'h5, 8'd0, d);
    check("R5 claim level", d, 1);
    rd(4'h2, 8'd0, d);
    check("R5 pending cleared", d, 0);
    wr(4'h5, 8'd0, 32'd1);
    idle(2);
    rd(4'h2, 8'd0, d);
    check("R6 re-raise after complete", d, 32'h02);
    rd(4'h5, 8'd0, d);
    check("R6 claim again", d, 1);
    irq_src[0] = 1'b0;
    wr(4'h5, 8'd0, 32'd1);
  endtask

  task automatic t_enable;
    logic [31:0] d;
    wr(4'h3, 8'd1, 32'h04);
    irq_src[0] = 1'b1;
    idle(3);
    check("R3 masked context line", 32'(irq_out[1]), 0);
    check("R3 enabled context line", 32'(irq_out[0]), 1);
    rd(4'h5, 8'd1, d);
    check("R3 masked claim", d, 0);
    rd(4'h5, 8'd0, d);
    check("R3 enabled claim", d, 1);
    irq_src[0] = 1'b0;
    wr(4'h5, 8'd0, 32'd1);
  endtask

  task automatic t_threshold;
    logic [31:0] d;
    wr(4'h4, 8'd0, 32'd3);
    irq_src[0] = 1'b1;
    idle(3);
    check("R4 below threshold line", 32'(irq_out[0]), 0);
    rd(4'h5, 8'd0, d);
    check("R4 below threshold claim", d, 0);
    wr(4'h4, 8'd0, 32'd2);
    idle(2);
    check("R4 equal threshold line", 32'(irq_out[0]), 1);
    wr(4'h0, 8'd1, 32'd0);
    idle(2);
    check("R4 priority zero line", 32'(irq_out[0]), 0);
    wr(4'h0, 8'd1, 32'd2);
    wr(4'h4, 8'd0, 32'd0);
    rd(4'h5, 8'd0, d);
    check("R4 claim restored", d, 1);
    irq_src[0] = 1'b0;
    wr(4'h5, 8'd0, 32'd1);
  endtask

  task automatic t_bad_complete;
    logic [31:0] d;
    irq_src[0] = 1'b1;
    idle(2);
    rd(4'h5, 8'd0, d);
    check("R9 setup claim", d, 1);
    wr(4'h5, 8'd0, 32'd2);
    wr(4'h5, 8'd0, 32'd0);
    wr(4'h5, 8'd0, 32'd5);
    idle(2);
    rd(4'h2, 8'd0, d);
    check("R9 stray completion ignored", d, 0);
    wr(4'h5, 8'd0, 32'd1);
    idle(2);
    rd(4'h2, 8'd0, d);
    check("R9 matching completion", d, 32'h02);
    irq_src[0] = 1'b0;
    rd(4'h5, 8'd0, d);
    wr(4'h5, 8'd0, 32'd1);
  endtask

  task automatic t_edge_drop;
    logic [31:0] d;
    wr(4'h1, 8'd4, 32'd0);
    wr(4'h0, 8'd4, 32'd4);
    pulse(3);
    rd(4'h5, 8'd0, d);
    check("R7 first edge claimed", d, 4);
    pulse(3);
    pulse(3);
    wr(4'h5, 8'd0, 32'd4);
    idle(2);
    rd(4'h5, 8'd0, d);
    check("R7 edges dropped", d, 0);
    rd(4'h2, 8'd0, d);
    check("R7 nothing pending", d, 0);
  endtask

  task automatic t_edge_queue;
    logic [31:0] d;
    wr(4'h1, 8'd5, 32'd2);
    wr(4'h0, 8'd5, 32'd4);
    pulse(4);
    pulse(4);
    rd(4'h5, 8'd0, d);
    check("R8 first edge", d, 5);
    pulse(4);
    pulse(4);
    for (int k = 0; k < 2; k++) begin
      wr(4'h5, 8'd0, 32'd5);
      idle(2);
      rd(4'h5, 8'd0, d);
      check("R8 queued edge delivered", d, 5);
    end
    wr(4'h5, 8'd0, 32'd5);
    idle(2);
    rd(4'h5, 8'd0, d);
    check("R8 queue saturated at depth", d, 0);
  endtask

  task automatic t_deleg;
    logic [31:0] d;
    rd(4'h0, 8'd1, d, 1'b1);
    check("R10 sup read blocked", d, 0);
    wr(4'h0, 8'd1, 32'd7, 1'b1);
    rd(4'h0, 8'd1, d);
    check("R10 sup write ignored", d, 2);
    wr(4'h7, 8'd0, 32'd1, 1'b1);
    rd(4'h0, 8'd1, d, 1'b1);
    check("R10 sup cannot set delegation", d, 0);
    wr(4'h7, 8'd0, 32'd1);
    rd(4'h0, 8'd1, d, 1'b1);
    check("R10 sup read delegated", d, 2);
    wr(4'h0, 8'd1, 32'd6, 1'b1);
    rd(4'h0, 8'd1, d);
    check("R10 sup write delegated", d, 6);
    rd(4'h7, 8'd0, d, 1'b1);
    check("R10 sup reads control as zero", d, 0);
    rd(4'h7, 8'd0, d);
    check("R10 machine reads control", d, 1);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    t_reset();
    t_priority();
    t_level();
    t_enable();
    t_threshold();
    t_bad_complete();
    t_edge_drop();
    t_edge_queue();
    t_deleg();
    done = 1;
    summary();
    $finish;
  end
endmodule